// File: doc/BRIEF.md
# Interlocked Clock Control Register

This block is a single byte-wide control register that chooses the clock sources of a chip and requests PLL power-down. Software writes it through a small bus made of a write strobe, an address and a data byte. Reads are combinational.

Three control outputs leave the register:
- a system clock source select, which picks either the 12 MHz main clock or the PLL output;
- a slow clock source select, which picks either the prescaled main clock or the 32.768 kHz oscillator;
- a PLL power-down request.

Two auxiliary clock enables and a power-on-reset status flag fill the upper bits.

Hardware filters each write against the register value held before that write and against a PLL-stable status input. The system clock can only move to a PLL that is powered and settled. The PLL can only be stopped while the main clock drives the system. A single write may try both steps at once: it may switch to the PLL and also power the PLL down. In that case the switch is kept and the power-down is refused. As a result, the block can never select a PLL that is stopped. A bit that is refused keeps its old value. The other bits of the same write are applied as written.

Top module: `clkctl_reg`

## Requirements
- R1: A synchronous active-high reset sets the value read back to 0x06. That is bit 1 = 1 (main clock), bit 2 = 1 (PLL powered down) and every other bit 0.
- R2: Bit 0 (slow clock select, 1 = oscillator), bit 3 and bit 4 (auxiliary enables) take the written value on every accepted write.
- R3: Writing 1 to bit 1 (switch to the main clock) is always accepted.
- R4: Writing 0 to bit 1 (switch to the PLL) is accepted only if bit 2 held 0 before the write and pll_stable is 1. Otherwise bit 1 keeps its value.
- R5: Writing 0 to bit 2 is always accepted. Writing 1 to bit 2 while it holds 0 is accepted only if bit 1 held 1 before the write and bit 1 is still 1 after this write. Otherwise bit 2 stays 0.
- R6: sys_main_sel = 0 together with pll_pwrdn = 1 never occurs.
- R7: por_in = 1 at a clock edge sets bit 5 in that edge. A write with bit 5 = 1 clears it, but only when por_in is 0; if por_in is 1, setting wins. A write with bit 5 = 0 leaves it unchanged.
- R8: Bits 7 and 6 always read 0, whatever was written to them.
- R9: rdata shows the register combinationally while addr equals REG_ADDR (default 2), and shows 0 otherwise. A write with a different address changes nothing.
- R10: slow_osc_sel, sys_main_sel and pll_pwrdn equal bits 0, 1 and 2. They change only at the clock edge that captures an accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when the address does not match |
| pll_stable | input | 1 | PLL output has settled |
| por_in | input | 1 | Power-on-reset event flag |
| slow_osc_sel | output | 1 | 1 = slow clock from the oscillator, 0 = from the prescaled main clock |
| sys_main_sel | output | 1 | 1 = system clock from the main clock, 0 = from the PLL |
| pll_pwrdn | output | 1 | 1 = request PLL power-down |

## Verification
A wrong interlock decision shows at the select or power-down outputs, and in the read-back byte, at the clock edge that captures the write. The bench therefore compares both after every write. The bench sweeps all 256 data values from each reachable combination of bits 1 and 2, with pll_stable both low and high. This sweep reaches every path through the filter, including the write that tries to switch and power down at once. A corrupted power-on-reset flag or a reserved bit shows in the read-back within one cycle.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int CTL_W    = 8;
  localparam int LOW_W    = 5;
  localparam int BIT_SLOW = 0;
  localparam int BIT_MAIN = 1;
  localparam int BIT_PD   = 2;
  localparam int BIT_AUX0 = 3;
  localparam int BIT_AUX1 = 4;
  localparam int BIT_POR  = 5;
  localparam logic [LOW_W-1:0] LOW_RST = 5'b00110;
endpackage

// File: rtl/clkctl_interlock.sv
module clkctl_interlock
  import clkctl_pkg::*;
(
  input  logic [LOW_W-1:0] cur,
  input  logic [LOW_W-1:0] wval,
  input  logic             pll_stable,
  output logic [LOW_W-1:0] nxt
);
  logic pll_ok;
  logic sel_n;
  logic pd_n;

  always_comb begin
    pll_ok = !cur[BIT_PD] && pll_stable;
    if (wval[BIT_MAIN])
      sel_n = 1'b1;
    else if (pll_ok)
      sel_n = 1'b0;
    else
      sel_n = cur[BIT_MAIN];
    if (!wval[BIT_PD])
      pd_n = 1'b0;
    else
      pd_n = cur[BIT_PD] || (cur[BIT_MAIN] && sel_n);
    nxt           = wval;
    nxt[BIT_MAIN] = sel_n;
    nxt[BIT_PD]   = pd_n;
  end
endmodule

// File: rtl/clkctl_porflag.sv
module clkctl_porflag (
  input  logic clk,
  input  logic rst,
  input  logic por_in,
  input  logic clr_req,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)
      flag <= 1'b0;
    else if (por_in)
      flag <= 1'b1;
    else if (clr_req)
      flag <= 1'b0;
  end

  // R7
  a_r7_por_sets: assert property (@(posedge clk) disable iff (rst)
    por_in |=> flag);
  a_r7_clear_needs_req: assert property (@(posedge clk) disable iff (rst)
    $fell(flag) |-> $past(clr_req));
endmodule

// File: rtl/clkctl_readmux.sv
module clkctl_readmux
  import clkctl_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LOW_W-1:0]  low,
  input  logic              por_bit,
  output logic [CTL_W-1:0]  rdata
);
  localparam int PAD_W = CTL_W - LOW_W - 1;

  always_comb begin
    if (addr == REG_ADDR)
      rdata = {{PAD_W{1'b0}}, por_bit, low};
    else
      rdata = '0;
  end
endmodule

// File: rtl/clkctl_reg.sv
module clkctl_reg
  import clkctl_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CTL_W-1:0]  wdata,
  output logic [CTL_W-1:0]  rdata,
  input  logic              pll_stable,
  input  logic              por_in,
  output logic              slow_osc_sel,
  output logic              sys_main_sel,
  output logic              pll_pwrdn
);
  logic             wr_hit;
  logic [LOW_W-1:0] low_q;
  logic [LOW_W-1:0] low_n;
  logic             por_q;

  assign wr_hit = wr_en && (addr == REG_ADDR);

  clkctl_interlock u_lock (
    .cur        (low_q),
    .wval       (wdata[LOW_W-1:0]),
    .pll_stable (pll_stable),
    .nxt        (low_n)
  );

  always_ff @(posedge clk) begin
    if (rst)
      low_q <= LOW_RST;
    else if (wr_hit)
      low_q <= low_n;
  end

  clkctl_porflag u_por (
    .clk     (clk),
    .rst     (rst),
    .por_in  (por_in),
    .clr_req (wr_hit && wdata[BIT_POR]),
    .flag    (por_q)
  );

  clkctl_readmux #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_rd (
    .addr    (addr),
    .low     (low_q),
    .por_bit (por_q),
    .rdata   (rdata)
  );

  assign slow_osc_sel = low_q[BIT_SLOW];
  assign sys_main_sel = low_q[BIT_MAIN];
  assign pll_pwrdn    = low_q[BIT_PD];

  // R4
  a_r4_pll_switch_legal: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_main_sel) |-> ($past(!pll_pwrdn) && $past(pll_stable)));
  // R5
  a_r5_pwrdn_legal: assert property (@(posedge clk) disable iff (rst)
    $rose(pll_pwrdn) |-> ($past(sys_main_sel) && sys_main_sel));
  // R6
  a_r6_never_off_pll: assert property (@(posedge clk) disable iff (rst)
    !(!sys_main_sel && pll_pwrdn));
  // R10
  a_r10_hold_without_write: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> $stable(low_q));
endmodule

// File: tb/clkctl_reg_test.sv
`timescale 1ns/1ps
module clkctl_reg_test;
  localparam logic [3:0] A = 4'h2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [3:0] addr = A;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       pll_stable = 1'b0;
  logic       por_in = 1'b0;
  logic       slow_osc_sel, sys_main_sel, pll_pwrdn;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  logic [7:0] model;

  always #4 clk = ~clk;

  clkctl_reg #(.ADDR_W(4), .REG_ADDR(A)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pll_stable(pll_stable), .por_in(por_in),
    .slow_osc_sel(slow_osc_sel), .sys_main_sel(sys_main_sel),
    .pll_pwrdn(pll_pwrdn)
  );

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] f_next(input logic [7:0] o, input logic [7:0] w,
                                        input logic st, input logic por);
    logic [7:0] n;
    n = 8'h00;
    n[0] = w[0];
    n[3] = w[3];
    n[4] = w[4];
    if (w[1]) n[1] = 1'b1;
    else if (!o[2] && st) n[1] = 1'b0;
    else n[1] = o[1];
    if (!w[2]) n[2] = 1'b0;
    else n[2] = o[2] || (o[1] && n[1]);
    if (por) n[5] = 1'b1;
    else if (w[5]) n[5] = 1'b0;
    else n[5] = o[5];
    return n;
  endfunction

  task automatic check_state();
    check8("R2 R3 R4 R5 R7 R8", rdata, model);
    check8("R10", {5'b0, pll_pwrdn, sys_main_sel, slow_osc_sel}, {5'b0, model[2:0]});
    check8("R6", {7'b0, !sys_main_sel && pll_pwrdn}, 8'h00);
  endtask

  task automatic do_write(input logic [7:0] w);
    @(negedge clk);
    wr_en = 1'b1; addr = A; wdata = w;
    model = f_next(model, w, pll_stable, por_in);
    @(negedge clk);
    wr_en = 1'b0; por_in = 1'b0;
    check_state();
  endtask

  task automatic goto_state(input int s);
    pll_stable = 1'b1;
    do_write(8'h06);
    do_write(8'h06);
    if (s >= 1) do_write(8'h02);
    if (s >= 2) do_write(8'h00);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    model = 8'h06;
    check8("R1", rdata, 8'h06);
    check8("R1", {5'b0, pll_pwrdn, sys_main_sel, slow_osc_sel}, 8'h06);

    // R4: switch refused while the PLL is powered down, even when stable
    pll_stable = 1'b1;
    do_write(8'h04);
    check8("R4", {7'b0, sys_main_sel}, 8'h01);

    // R5: switch and power-down in one write keep only the switch
    do_write(8'h02);
    do_write(8'h04);
    check8("R5", rdata, 8'h00);
    // R3 leaving the PLL always works
    pll_stable = 1'b0;
    do_write(8'h02);
    check8("R3", rdata, 8'h02);

    // R9 mismatch address reads zero and writes have no effect
    @(negedge clk);
    addr = 4'h5;
    #1 check8("R9", rdata, 8'h00);
    wr_en = 1'b1; wdata = 8'hFD;
    @(negedge clk);
    wr_en = 1'b0; addr = A;
    #1 check8("R9", rdata, model);

    // R7 power-on flag
    @(negedge clk);
    por_in = 1'b1;
    @(negedge clk);
    por_in = 1'b0;
    model[5] = 1'b1;
    check8("R7", rdata, model);
    do_write({3'b000, model[4:0]});
    check8("R7", {7'b0, rdata[5]}, 8'h01);
    por_in = 1'b1;
    do_write({3'b001, model[4:0]});
    check8("R7", {7'b0, rdata[5]}, 8'h01);
    do_write({3'b001, model[4:0]});
    check8("R7", {7'b0, rdata[5]}, 8'h00);

    // R8 reserved bits
    do_write(8'hC2);
    check8("R8", rdata & 8'hC0, 8'h00);

    // sweep: each reachable (bit1,bit2) state x pll_stable x all data bytes
    for (int s = 0; s < 3; s++)
      for (int st = 0; st < 2; st++)
        for (int w = 0; w < 256; w++) begin
          goto_state(s);
          pll_stable = st[0];
          do_write(w[7:0]);
        end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule